// File: doc/BRIEF.md
# Read completion split sequencer

This block sits between the logic that accepts non-posted requests and the formatter that writes completion packets onto a stream. It takes one request at a time: start byte address, byte length, tag, requester identifier, whether it is a read, and a code for the largest payload one completion may carry. From these it produces a sequence of segment commands. Each command describes one completion packet, which gets its own descriptor. The command gives the segment's start address, the bytes still owed from that address to the end of the block, the padded Dword length, and a flag that marks the final segment.

A read is cut at every aligned payload-size boundary. The first segment runs from the start address to the first boundary above it, or to the end of the block if that comes first. Each later segment is a full payload, except the last one. A request that is not a read yields exactly one command with no data. Every command carries successful completion status, so no status field is needed.

Both sides use valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. A segment is handed off when `seg_valid` and `seg_ready` are both high. While `seg_valid` is high and `seg_ready` is low, the current segment waits with all its fields unchanged. `req_ready` stays low until the final segment has been handed off, so a stalled downstream holds off further requests without losing any.

Top module: `cpl_split_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `seg_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `seg_valid` rises in the next cycle. `req_ready` then stays 0, and other requests offered meanwhile are ignored, until the edge that hands off the final segment. In the cycle after that edge, `req_ready` is 1 and `seg_valid` is 0.
- R3: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid` stays 1 and every segment field holds its value.
- R4: A request with `req_is_read`=0 yields exactly one segment with `seg_last`=1, `seg_has_data`=0, `seg_dw_len`=0, `seg_bytes_left`=0 and `seg_lower_addr`=0.
- R5: `req_mps_sel` is sampled when the request is taken and sets the maximum payload: code 0 gives 128 bytes, code 1 gives 256 bytes, and codes 2 and 3 give 512 bytes.
- R6: The first segment of a read starts at `req_addr` and ends at the first maximum-payload-aligned boundary above it, or at the end of the block if that is nearer. No segment crosses such a boundary.
- R7: Each later segment of a read starts at the boundary where the previous one ended. It is a full maximum payload, except the final segment, which holds whatever is left.
- R8: `seg_bytes_left` equals the number of bytes from the segment's start address to the end of the block. For the first segment this is `req_len`; it then falls by the size of each segment handed off.
- R9: `seg_dw_len` = ceil((start address mod 4 + segment bytes) / 4). This counts a partial first Dword and a partial last Dword as whole Dwords.
- R10: `seg_addr` is the segment start byte address. For reads, `seg_lower_addr` is bits [6:0] of it, with the Dword address in bits [6:2].
- R11: Every segment carries the request's tag and identifier unchanged and has `seg_has_data`=1 for reads. `seg_last` is 1 only on the final segment.
- R12: Read lengths run from 1 up to 4096 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 16 | Request start byte address |
| req_len | input | 13 | Request byte length |
| req_tag | input | 8 | Request tag |
| req_id | input | 16 | Requester identifier |
| req_is_read | input | 1 | 1 for a read returning data |
| req_mps_sel | input | 2 | Maximum payload code |
| seg_valid | output | 1 | Segment command offered |
| seg_ready | input | 1 | Formatter takes the segment |
| seg_addr | output | 16 | Segment start byte address |
| seg_lower_addr | output | 7 | Low address bits for the descriptor |
| seg_bytes_left | output | 13 | Bytes from segment start to block end |
| seg_dw_len | output | 8 | Padded Dword length of the segment |
| seg_last | output | 1 | Final segment of the request |
| seg_has_data | output | 1 | Segment carries payload |
| seg_tag | output | 8 | Tag of the request |
| seg_id | output | 16 | Requester identifier |

## Verification
The hardest case to reach from the ports is a new request arriving while a long split sequence is stalled mid-way. The bench drives it directly: it keeps `req_valid` high with different field values during the whole sequence, and it holds `seg_ready` low for several cycles on a segment. It then checks that every later segment still belongs to the first request. It also checks that the held segment did not change and that `req_ready` stayed low throughout.

// File: rtl/cpl_split_pkg.sv
package cpl_split_pkg;

  typedef enum logic [1:0] {
    MPS_128  = 2'd0,
    MPS_256  = 2'd1,
    MPS_512  = 2'd2,
    MPS_512X = 2'd3
  } mps_code_e;

  // Payload size in bytes for a payload code (always a power of two)
  function automatic int unsigned mps_bytes(input logic [1:0] code);
    case (mps_code_e'(code))
      MPS_128: return 128;
      MPS_256: return 256;
      default: return 512;
    endcase
  endfunction

endpackage

// File: rtl/cpl_seg_calc.sv
module cpl_seg_calc #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13,
  parameter int DW_W   = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  cur_rem,
  input  logic [LEN_W-1:0]  cur_mps,
  input  logic              cur_read,
  output logic [LEN_W-1:0]  seg_bytes,
  output logic [DW_W-1:0]   dw_len,
  output logic              last,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [LEN_W-1:0]  nxt_rem
);
  logic [LEN_W-1:0] off;
  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] take;
  logic [LEN_W:0]   dw_sum;

  always_comb begin
    off    = cur_addr[LEN_W-1:0] & (cur_mps - 1'b1);
    room   = cur_mps - off;
    take   = (cur_rem < room) ? cur_rem : room;
    dw_sum = {1'b0, take} + (LEN_W+1)'(cur_addr[1:0]) + (LEN_W+1)'(3);
    if (cur_read) begin
      seg_bytes = take;
      dw_len    = DW_W'(dw_sum >> 2);
      last      = (take == cur_rem);
    end else begin
      seg_bytes = '0;
      dw_len    = '0;
      last      = 1'b1;
    end
    nxt_addr = cur_addr + ADDR_W'(take);
    nxt_rem  = cur_rem - take;
  end

endmodule

// File: rtl/cpl_seg_ctrl.sv
module cpl_seg_ctrl #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_is_read,
  input  logic [LEN_W-1:0]  req_mps,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ID_W-1:0]   req_id,
  input  logic              seg_fire,
  input  logic              seg_last,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [LEN_W-1:0]  nxt_rem,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_rem,
  output logic [LEN_W-1:0]  cur_mps,
  output logic              cur_read,
  output logic [TAG_W-1:0]  cur_tag,
  output logic [ID_W-1:0]   cur_id
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      cur_rem  <= '0;
      cur_mps  <= '0;
      cur_read <= 1'b0;
      cur_tag  <= '0;
      cur_id   <= '0;
    end else if (req_fire) begin
      busy     <= 1'b1;
      cur_addr <= req_addr;
      cur_rem  <= req_len;
      cur_mps  <= req_mps;
      cur_read <= req_is_read;
      cur_tag  <= req_tag;
      cur_id   <= req_id;
    end else if (seg_fire) begin
      if (seg_last) begin
        busy <= 1'b0;
      end else begin
        cur_addr <= nxt_addr;
        cur_rem  <= nxt_rem;
      end
    end
  end

  AST_MPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !seg_fire |=> busy && $stable(cur_mps) && $stable(cur_tag)); // R5

endmodule

// File: rtl/cpl_split_seq.sv
module cpl_split_seq
  import cpl_split_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 13,
  parameter int TAG_W   = 8,
  parameter int ID_W    = 16,
  parameter int MPS_MAX = 512,
  localparam int DW_W   = $clog2(MPS_MAX / 4) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_is_read,
  input  logic [1:0]        req_mps_sel,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [6:0]        seg_lower_addr,
  output logic [LEN_W-1:0]  seg_bytes_left,
  output logic [DW_W-1:0]   seg_dw_len,
  output logic              seg_last,
  output logic              seg_has_data,
  output logic [TAG_W-1:0]  seg_tag,
  output logic [ID_W-1:0]   seg_id
);
  logic              busy, req_fire, seg_fire, cur_read;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [LEN_W-1:0]  cur_rem, nxt_rem, cur_mps, seg_bytes;
  logic [LEN_W-1:0]  req_mps;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign seg_valid = busy;
  assign seg_fire  = seg_valid && seg_ready;
  assign req_mps   = LEN_W'(mps_bytes(req_mps_sel));

  cpl_seg_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_addr(req_addr),
    .req_len(req_len), .req_is_read(req_is_read), .req_mps(req_mps),
    .req_tag(req_tag), .req_id(req_id), .seg_fire(seg_fire), .seg_last(seg_last),
    .nxt_addr(nxt_addr), .nxt_rem(nxt_rem), .busy(busy), .cur_addr(cur_addr),
    .cur_rem(cur_rem), .cur_mps(cur_mps), .cur_read(cur_read),
    .cur_tag(seg_tag), .cur_id(seg_id)
  );

  cpl_seg_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DW_W(DW_W)) u_calc (
    .cur_addr(cur_addr), .cur_rem(cur_rem), .cur_mps(cur_mps), .cur_read(cur_read),
    .seg_bytes(seg_bytes), .dw_len(seg_dw_len), .last(seg_last),
    .nxt_addr(nxt_addr), .nxt_rem(nxt_rem)
  );

  assign seg_addr       = cur_addr;
  assign seg_has_data   = cur_read;
  assign seg_lower_addr = cur_read ? cur_addr[6:0] : 7'd0;
  assign seg_bytes_left = cur_read ? cur_rem : '0;

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_bytes_left)
      && $stable(seg_dw_len) && $stable(seg_last)); // R3
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !req_ready); // R2
  AST_NONREAD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_has_data |-> seg_last && seg_dw_len == '0); // R4
  AST_SEG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_has_data |->
      ({1'b0, seg_addr[LEN_W-1:0] & (cur_mps - 1'b1)} + {1'b0, seg_bytes}) <= {1'b0, cur_mps}); // R6
  AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire && !seg_last |=> seg_valid && (seg_addr[LEN_W-1:0] & (cur_mps - 1'b1)) == '0); // R7
  AST_DW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_has_data && seg_bytes != '0 |->
      seg_dw_len != '0 && {5'd0, seg_dw_len} <= (cur_mps >> 2)); // R9

endmodule

// File: tb/cpl_split_seq_bench.sv
`timescale 1ns/1ps
module cpl_split_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0;
  logic [12:0] req_len = '0;
  logic [7:0]  req_tag = '0;
  logic [15:0] req_id = '0;
  logic        req_is_read = 1'b0;
  logic [1:0]  req_mps_sel = '0;
  logic        seg_valid, seg_ready = 1'b0;
  logic [15:0] seg_addr;
  logic [6:0]  seg_lower_addr;
  logic [12:0] seg_bytes_left;
  logic [7:0]  seg_dw_len;
  logic        seg_last, seg_has_data;
  logic [7:0]  seg_tag;
  logic [15:0] seg_id;

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  cpl_split_seq u_cpl_split_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag), .req_id(req_id),
    .req_is_read(req_is_read), .req_mps_sel(req_mps_sel), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_lower_addr(seg_lower_addr),
    .seg_bytes_left(seg_bytes_left), .seg_dw_len(seg_dw_len), .seg_last(seg_last),
    .seg_has_data(seg_has_data), .seg_tag(seg_tag), .seg_id(seg_id)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int mps_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 128 : (sel == 2'd1) ? 256 : 512;
  endfunction

  // Compare the presented segment with the expected one
  task automatic chk_seg(input int a, input int r, input int sb, input bit rd,
                         input logic [7:0] tag, input logic [15:0] id, input bit last);
    chk(seg_valid == 1'b1, "R2 seg_valid", seg_valid, 1);
    chk(req_ready == 1'b0, "R2 req_ready busy", req_ready, 0);
    chk(seg_tag == tag && seg_id == id, "R11 tag/id", seg_tag, tag);
    chk(seg_last == last, "R11 last flag", seg_last, last);
    if (rd) begin
      chk(seg_addr == 16'(a), "R7 seg_addr", seg_addr, a);
      chk(seg_lower_addr == 7'(a), "R10 lower addr", seg_lower_addr, a % 128);
      chk(seg_bytes_left == 13'(r), "R8 bytes left", seg_bytes_left, r);
      chk(seg_dw_len == 8'(((a % 4) + sb + 3) / 4), "R9 dw len", seg_dw_len,
          ((a % 4) + sb + 3) / 4);
      chk(seg_has_data == 1'b1, "R11 has data", seg_has_data, 1);
    end else begin
      chk(seg_has_data == 1'b0 && seg_dw_len == 0 && seg_bytes_left == 0 &&
          seg_lower_addr == 0, "R4 no-data shape", seg_dw_len, 0);
    end
  endtask

  task automatic run_req(input int a0, input int len, input bit rd, input logic [1:0] sel,
                         input logic [7:0] tag, input logic [15:0] id,
                         input int stall, input bit spam);
    int a = a0, r = len, idx = 0, mps = mps_of(sel);
    bit done = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 16'(a0); req_len = 13'(len); req_is_read = rd;
    req_mps_sel = sel; req_tag = tag; req_id = id;
    @(posedge clk);
    @(negedge clk);
    if (spam) begin
      req_addr = 16'h0FF3; req_len = 13'd9; req_tag = ~tag; req_id = ~id; req_mps_sel = 2'd0;
    end else req_valid = 0;
    while (!done) begin
      int room = mps - (a % mps);
      int sb = rd ? ((r < room) ? r : room) : 0;
      bit last = !rd || (sb == r);
      chk_seg(a, r, sb, rd, tag, id, last);
      if (rd && idx == 0) chk(a + sb <= (a / mps + 1) * mps, "R6 first seg window", sb, room);
      if (rd && idx > 0 && !last) chk(sb == mps, "R7 full segment", sb, mps);
      if (last) req_valid = 0;
      if (stall > 0 && idx == 1) begin
        repeat (stall) begin
          @(negedge clk);
          chk_seg(a, r, sb, rd, tag, id, last);   // R3 held while stalled
        end
      end
      seg_ready = 1;
      @(posedge clk);
      @(negedge clk);
      seg_ready = 0;
      a += sb; r -= sb; idx++;
      done = last;
    end
    chk(seg_valid == 1'b0 && req_ready == 1'b1, "R2 idle after last", seg_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(seg_valid == 1'b0, "R1 seg_valid", seg_valid, 0);
  endtask

  task automatic t_split128();   run_req(16'h0005, 300, 1, 2'd0, 8'h11, 16'h0101, 0, 0); endtask
  task automatic t_small();      run_req(16'h0007, 3,   1, 2'd1, 8'h22, 16'h0202, 0, 0); endtask
  task automatic t_nonread();    run_req(16'h1234, 4,   0, 2'd2, 8'h33, 16'h0303, 0, 0); endtask
  task automatic t_stall256();   run_req(16'h00FE, 700, 1, 2'd1, 8'h44, 16'h0404, 5, 1); endtask
  task automatic t_full512();    run_req(16'h0400, 4096, 1, 2'd2, 8'h55, 16'h0505, 0, 0); endtask
  task automatic t_code3();      run_req(16'h01F1, 900, 1, 2'd3, 8'h66, 16'h0606, 0, 0); endtask // R5
  task automatic t_one_byte();   run_req(16'h007F, 1,   1, 2'd0, 8'h77, 16'h0707, 0, 0); endtask // R12
  task automatic t_edge();       run_req(16'h007F, 2,   1, 2'd0, 8'h88, 16'h0808, 0, 0); endtask // R6

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1;
    t_reset();
    t_split128();
    t_small();
    t_nonread();
    t_stall256();
    t_full512();
    t_code3();
    t_one_byte();
    t_edge();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

endmodule